// File: doc/BRIEF.md
# Boot-Aware Remappable Address Decoder

This block turns one bus master's address into a one-hot select for one of six slave ports and an address offset relative to the start of the region that was hit. Each master on the interconnect has its own copy of the decoder, and every copy uses the same address map. The decoder does not handle arbitration, bursts or data.

The low window at address zero is the boot window, and the slave behind it can change. When reset releases, the decoder samples a boot-mode pin once. A low pin places the internal ROM in the boot window and a high pin places the external bus interface there. After that, a one-cycle remap command moves internal SRAM 0 into the boot window, so software can relocate the exception vectors. The remap state stays set until the next reset. All other regions map to fixed slaves. An address outside every region raises a decode-error flag and drives no select.

Slave select bit positions are: bit 0 SRAM 0 (16 KB), bit 1 SRAM 1 (16 KB), bit 2 internal ROM, bit 3 USB host user-interface port, bit 4 external bus interface, bit 5 peripheral bridge.

Address map (region: base, size):

- boot window: 0x0000_0000, 1 MB
- ROM: 0x0010_0000, 32 KB
- SRAM 0: 0x0020_0000, 16 KB
- SRAM 1: 0x0030_0000, 16 KB
- USB UI: 0x0050_0000, 16 KB
- external bus: 0x1000_0000, 256 MB
- peripherals: 0xF000_0000, 256 MB

Top module: `boot_remap_decoder`

## Requirements
- R1: While reset is held, both the latched boot mode and the remap state are cleared, so any boot-window address selects the ROM (bit 2).
- R2: If the boot pin is low at the first clock edge with reset released, boot-window addresses then select the ROM (bit 2).
- R3: If the boot pin is high at the first clock edge with reset released, boot-window addresses then select the external bus interface (bit 4).
- R4: Changes on the boot pin after that first edge have no effect on the boot-window selection.
- R5: A remap pulse that is high at a clock edge makes boot-window addresses select SRAM 0 (bit 0) from that edge on. Before the edge, the previous selection holds.
- R6: The remap state stays set whatever the remap input does afterwards. Only reset clears it, and after reset the boot window follows the boot pin again.
- R7: ROM, SRAM 0, SRAM 1, USB UI, external bus and peripheral regions select bits 2, 0, 1, 3, 4 and 5 in every boot and remap state.
- R8: An address in no region drives decodeErr high, slaveSel to all zeros and offset to zero. This includes the first address past the end of a region.
- R9: slaveSel has at most one bit set, and exactly one bit is set whenever decodeErr is low. Both outputs follow the address combinationally in the same cycle.
- R10: offset equals the address minus the base of the region that was hit. In the boot window it equals the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| bootPin | input | 1 | Boot-mode select, sampled when reset releases (1 = external) |
| remapCmd | input | 1 | Single-cycle remap command |
| addr | input | 32 | Master address |
| slaveSel | output | 6 | One-hot slave select |
| offset | output | 32 | Slave-relative address |
| decodeErr | output | 1 | Address hits no region |

## Verification
The only internal state is the latched boot mode and the remap flag. An error in either shows up as a wrong select bit the first time the master touches the boot window, with no extra delay. Fixed regions never reveal it. For this reason the bench reads the boot window at each transition: in reset, on the cycle after reset releases, after the pin toggles, and on either side of the remap edge. A mistake in the region compare shows up at once on the outputs, most clearly at region top and one-past-top addresses, as a wrong select bit, a wrong offset or a missing error flag.

// File: rtl/boot_remap_pkg.sv
package boot_remap_pkg;

  parameter int ADDR_W      = 32;
  parameter int NUM_SLAVES  = 6;
  parameter int NUM_REGIONS = 7;
  localparam int SLV_IDX_W  = $clog2(NUM_SLAVES);
  localparam int REG_IDX_W  = $clog2(NUM_REGIONS);

  typedef enum logic [SLV_IDX_W-1:0] {
    SLV_SRAM0  = 3'd0,
    SLV_SRAM1  = 3'd1,
    SLV_ROM    = 3'd2,
    SLV_USBUI  = 3'd3,
    SLV_EXTBUS = 3'd4,
    SLV_PERIPH = 3'd5
  } slaveIdx_t;

  localparam int BOOT_REGION = 0;

  typedef struct packed {
    logic bootExt;
    logic remapped;
  } ctrlStrobes_t;

  function automatic logic [ADDR_W-1:0] regionBase(input int r);
    case (r)
      0:       regionBase = 32'h0000_0000;
      1:       regionBase = 32'h0010_0000;
      2:       regionBase = 32'h0020_0000;
      3:       regionBase = 32'h0030_0000;
      4:       regionBase = 32'h0050_0000;
      5:       regionBase = 32'h1000_0000;
      default: regionBase = 32'hF000_0000;
    endcase
  endfunction

  function automatic int regionLog2(input int r);
    case (r)
      0:       regionLog2 = 20;
      1:       regionLog2 = 15;
      2:       regionLog2 = 14;
      3:       regionLog2 = 14;
      4:       regionLog2 = 14;
      default: regionLog2 = 28;
    endcase
  endfunction

  function automatic slaveIdx_t regionFixedSlave(input int r);
    case (r)
      1:       regionFixedSlave = SLV_ROM;
      2:       regionFixedSlave = SLV_SRAM0;
      3:       regionFixedSlave = SLV_SRAM1;
      4:       regionFixedSlave = SLV_USBUI;
      5:       regionFixedSlave = SLV_EXTBUS;
      6:       regionFixedSlave = SLV_PERIPH;
      default: regionFixedSlave = SLV_ROM;
    endcase
  endfunction

  function automatic slaveIdx_t bootSlave(input ctrlStrobes_t s);
    if (s.remapped)     bootSlave = SLV_SRAM0;
    else if (s.bootExt) bootSlave = SLV_EXTBUS;
    else                bootSlave = SLV_ROM;
  endfunction

endpackage

// File: rtl/boot_remap_ctrl.sv
module boot_remap_ctrl
  import boot_remap_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         bootPin,
  input  logic         remapCmd,
  output ctrlStrobes_t strobes
);

  logic captureArmed;
  logic bootExtQ;
  logic remappedQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      captureArmed <= 1'b1;
      bootExtQ     <= 1'b0;
      remappedQ    <= 1'b0;
    end else begin
      if (captureArmed) begin
        bootExtQ     <= bootPin;
        captureArmed <= 1'b0;
      end
      if (remapCmd) begin
        remappedQ <= 1'b1;
      end
    end
  end

  always_comb begin
    strobes.bootExt  = bootExtQ;
    strobes.remapped = remappedQ;
  end

endmodule

// File: rtl/boot_remap_dp.sv
module boot_remap_dp
  import boot_remap_pkg::*;
(
  input  logic [ADDR_W-1:0]     addr,
  input  ctrlStrobes_t          strobes,
  output logic [NUM_SLAVES-1:0] slaveSel,
  output logic [ADDR_W-1:0]     offset,
  output logic                  decodeErr
);

  logic [NUM_REGIONS-1:0] regionHit;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    localparam logic [ADDR_W-1:0] BASE = regionBase(r);
    localparam int                SH   = regionLog2(r);
    assign regionHit[r] = ((addr >> SH) == (BASE >> SH));
  end

  slaveIdx_t         pickSlave;
  logic [ADDR_W-1:0] pickBase;
  logic              anyHit;

  always_comb begin
    pickSlave = SLV_ROM;
    pickBase  = '0;
    anyHit    = 1'b0;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (regionHit[r] && !anyHit) begin
        anyHit    = 1'b1;
        pickBase  = regionBase(r);
        pickSlave = (r == BOOT_REGION) ? bootSlave(strobes) : regionFixedSlave(r);
      end
    end
  end

  always_comb begin
    slaveSel  = '0;
    offset    = '0;
    decodeErr = !anyHit;
    if (anyHit) begin
      slaveSel[pickSlave] = 1'b1;
      offset              = addr - pickBase;
    end
  end

endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder
  import boot_remap_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  bootPin,
  input  logic                  remapCmd,
  input  logic [ADDR_W-1:0]     addr,
  output logic [NUM_SLAVES-1:0] slaveSel,
  output logic [ADDR_W-1:0]     offset,
  output logic                  decodeErr
);

  ctrlStrobes_t strobes;

  boot_remap_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bootPin  (bootPin),
    .remapCmd (remapCmd),
    .strobes  (strobes)
  );

  boot_remap_dp u_dp (
    .addr      (addr),
    .strobes   (strobes),
    .slaveSel  (slaveSel),
    .offset    (offset),
    .decodeErr (decodeErr)
  );

endmodule

// File: rtl/boot_remap_checker.sv
module boot_remap_checker
  import boot_remap_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  remapCmd,
  input logic [ADDR_W-1:0]     addr,
  input logic [NUM_SLAVES-1:0] slaveSel,
  input logic [ADDR_W-1:0]     offset,
  input logic                  decodeErr
);

  logic seenRemap;
  logic [1:0] runCycles;
  logic inBoot;

  assign inBoot = (addr < 32'h0010_0000);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenRemap <= 1'b0;
      runCycles <= '0;
    end else begin
      if (remapCmd) seenRemap <= 1'b1;
      if (runCycles != 2'd3) runCycles <= runCycles + 2'd1;
    end
  end

  // R9
  p_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(slaveSel) && (decodeErr != (|slaveSel)));

  // R8
  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    decodeErr |-> (slaveSel == '0) && (offset == '0));

  // R10
  p_boot_offset_r10: assert property (@(posedge clk) disable iff (!rstN)
    inBoot |-> !decodeErr && (offset == addr));

  // R5 / R6
  p_remap_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (seenRemap && inBoot) |-> slaveSel[SLV_SRAM0]);

  // R4
  p_boot_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (runCycles >= 2'd2 && !seenRemap && inBoot && $past(inBoot)) |-> (slaveSel == $past(slaveSel)));

endmodule

bind boot_remap_decoder boot_remap_checker u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .remapCmd  (remapCmd),
  .addr      (addr),
  .slaveSel  (slaveSel),
  .offset    (offset),
  .decodeErr (decodeErr)
);

// File: tb/boot_remap_decoder_tb.sv
module boot_remap_decoder_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bootPin = 1'b0;
  logic        remapCmd = 1'b0;
  logic [31:0] addr = '0;
  logic [5:0]  slaveSel;
  logic [31:0] offset;
  logic        decodeErr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [5:0] S_SRAM0 = 6'b000001;
  localparam logic [5:0] S_SRAM1 = 6'b000010;
  localparam logic [5:0] S_ROM   = 6'b000100;
  localparam logic [5:0] S_USB   = 6'b001000;
  localparam logic [5:0] S_EXT   = 6'b010000;
  localparam logic [5:0] S_PER   = 6'b100000;

  always #2 clk = ~clk;

  boot_remap_decoder u_dut (
    .clk(clk), .rstN(rstN), .bootPin(bootPin), .remapCmd(remapCmd),
    .addr(addr), .slaveSel(slaveSel), .offset(offset), .decodeErr(decodeErr)
  );

  task automatic probe(input logic [31:0] a, input logic [5:0] expSel,
                       input logic [31:0] expOff, input logic expErr, input string tag);
    addr = a;
    #1;
    checks++;
    if (slaveSel !== expSel || offset !== expOff || decodeErr !== expErr) begin
      failures++;
      $display("FAIL %s addr=%h sel=%b off=%h err=%b expected sel=%b off=%h err=%b",
               tag, a, slaveSel, offset, decodeErr, expSel, expOff, expErr);
    end
  endtask

  task automatic doReset(input logic pin);
    @(negedge clk);
    rstN = 1'b0;
    bootPin = ~pin;
    remapCmd = 1'b0;
    repeat (3) @(negedge clk);
    bootPin = pin;
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic testResetState();
    @(negedge clk);
    rstN = 1'b0;
    bootPin = 1'b1;
    repeat (2) @(negedge clk);
    probe(32'h0000_0040, S_ROM, 32'h0000_0040, 1'b0, "R1 boot window in reset");
  endtask

  task automatic testInternalBoot();
    doReset(1'b0);
    probe(32'h0000_0104, S_ROM, 32'h0000_0104, 1'b0, "R2 internal boot");
    probe(32'h000F_FFFF, S_ROM, 32'h000F_FFFF, 1'b0, "R10 boot window top");
    bootPin = 1'b1;
    repeat (3) @(negedge clk);
    probe(32'h0000_0000, S_ROM, 32'h0000_0000, 1'b0, "R4 pin rise ignored");
  endtask

  task automatic testFixedMap(input string mode);
    probe(32'h0010_7FFC, S_ROM,   32'h0000_7FFC, 1'b0, {"R7 rom top ", mode});
    probe(32'h0020_3FFF, S_SRAM0, 32'h0000_3FFF, 1'b0, {"R7 sram0 top ", mode});
    probe(32'h0030_0010, S_SRAM1, 32'h0000_0010, 1'b0, {"R7 sram1 ", mode});
    probe(32'h0050_0020, S_USB,   32'h0000_0020, 1'b0, {"R7 usb ui ", mode});
    probe(32'h1234_5678, S_EXT,   32'h0234_5678, 1'b0, {"R10 ext bus offset ", mode});
    probe(32'hF00F_0000, S_PER,   32'h000F_0000, 1'b0, {"R10 periph offset ", mode});
  endtask

  task automatic testHoles();
    probe(32'h0010_8000, 6'b0, 32'h0, 1'b1, "R8 past rom end");
    probe(32'h0020_4000, 6'b0, 32'h0, 1'b1, "R8 past sram0 end");
    probe(32'h0040_0000, 6'b0, 32'h0, 1'b1, "R8 gap");
    probe(32'h8000_0000, 6'b0, 32'h0, 1'b1, "R8 high gap");
    probe(32'h0050_4000, 6'b0, 32'h0, 1'b1, "R9 past usb end");
  endtask

  task automatic testExternalBootAndRemap();
    doReset(1'b1);
    probe(32'h0000_0200, S_EXT, 32'h0000_0200, 1'b0, "R3 external boot");
    bootPin = 1'b0;
    repeat (2) @(negedge clk);
    probe(32'h0000_0200, S_EXT, 32'h0000_0200, 1'b0, "R4 pin fall ignored");
    remapCmd = 1'b1;
    probe(32'h0000_0008, S_EXT, 32'h0000_0008, 1'b0, "R5 before remap edge");
    @(negedge clk);
    remapCmd = 1'b0;
    probe(32'h0000_0008, S_SRAM0, 32'h0000_0008, 1'b0, "R5 after remap edge");
    repeat (5) @(negedge clk);
    probe(32'h0000_3000, S_SRAM0, 32'h0000_3000, 1'b0, "R6 remap sticky");
    testFixedMap("remapped");
    doReset(1'b1);
    probe(32'h0000_0008, S_EXT, 32'h0000_0008, 1'b0, "R6 reset clears remap");
    doReset(1'b0);
    probe(32'h0000_0008, S_ROM, 32'h0000_0008, 1'b0, "R6 reset back to rom");
  endtask

  initial begin
    testResetState();
    testInternalBoot();
    testFixedMap("internal");
    testHoles();
    testExternalBootAndRemap();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule